// File: doc/BRIEF.md
# Counter-Sequenced One-Hot ALU Processor

This block is a small processor datapath that needs no instruction stream. Two operands are presented on input buses. A strobe decides whether the block takes the live bus values or keeps the copies it captured earlier. A free-running step counter feeds a decoder, and the decoder produces a one-hot operation code. That code chooses one of eight arithmetic or bitwise operations, so each rising clock edge registers the result of the next operation in a fixed cycle.

The registered result leaves the block inverted, ready to drive LEDs that light on a low level. The one-hot code for the operation that the next edge will apply is also brought out. A host can line each displayed result up with its operation, because the displayed result always belongs to the code that was on that output one cycle earlier. Reset is synchronous and active high. It returns the sequence to the addition step and clears both the result and the captured operands.

Top module: `seq_alu_proc`

## Requirements
- R1: The step counter advances by one on every rising edge without reset and wraps from 7 back to 0. The `opcode` output carries a single 1 at bit position equal to the counter value.
- R2: A rising edge with `rst` high sets the counter to 0, clears the result register to 0 so that `led_n` reads all ones, and clears both captured operands to 0.
- R3: Bit k of `opcode` selects operation k in this order: bit0 add, bit1 subtract, bit2 invert A, bit3 NAND, bit4 NOR, bit5 AND, bit6 OR, bit7 XOR.
- R4: The add step registers (A + B) modulo 256.
- R5: The subtract step registers (A − B) modulo 256.
- R6: The invert step registers the bitwise complement of A, and B has no effect on it.
- R7: The NAND, NOR, AND, OR and XOR steps register the matching bitwise function of A and B.
- R8: The result changes only at a rising edge. The first edge after reset is released registers the sum, and each later edge registers the next operation in the R3 order.
- R9: At an edge with `strobe` high, the live `a_in`/`b_in` values are used and captured. At an edge with `strobe` low, the captured values are used and bus changes are ignored.
- R10: The `led_n` output is the bitwise complement of the registered result, so a result bit of 1 drives its pin to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | High: use and capture the live operand buses |
| a_in | input | 8 | Operand A bus |
| b_in | input | 8 | Operand B bus |
| led_n | output | 8 | Inverted registered result (active-low LEDs) |
| opcode | output | 8 | One-hot code of the operation applied at the next edge |

## Verification
The bench builds the block at its default 8-bit operand width with the 3-bit step counter. At that width every value of A can be swept, each paired with four different B values across a full eight-step cycle. This covers every operation against every A, including the carry and borrow wrap cases of add and subtract. Further passes hold the strobe low while the buses change, and apply reset in the middle of a cycle. These runs expose whether stale or live operands reach the result, and whether the sequence restarts at the sum.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;

    localparam int STEP_W  = 3;
    localparam int NUM_OPS = 1 << STEP_W;

    typedef enum logic [STEP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_NOT  = 3'd2,
        OP_NAND = 3'd3,
        OP_NOR  = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_XOR  = 3'd7
    } op_idx_e;

    typedef logic [STEP_W-1:0]  step_t;
    typedef logic [NUM_OPS-1:0] opcode_t;

    function automatic opcode_t code_of(op_idx_e idx);
        return opcode_t'(1) << idx;
    endfunction

endpackage

// File: rtl/step_counter.sv
module step_counter
    import seq_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output step_t step
);

    step_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + STEP_W'(1);
        end
    end

    assign step = cnt_q;

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_q == $past(cnt_q) + STEP_W'(1)); // R1

    AST_STEP_RESET: assert property (@(posedge clk)
        rst |=> cnt_q == '0); // R2

endmodule

// File: rtl/onehot_decoder.sv
module onehot_decoder
    import seq_alu_pkg::*;
(
    input  step_t   step,
    output opcode_t sel
);

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_line
        assign sel[k] = (step == STEP_W'(k));
    end

endmodule

// File: rtl/operand_latch.sv
module operand_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q_eff
);

    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= d;
        end
    end

    assign q_eff = load ? d : held_q;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> held_q == $past(held_q)); // R9

endmodule

// File: rtl/alu_core.sv
module alu_core
    import seq_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  opcode_t           sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);

    logic [DATA_W-1:0] res_d;
    logic [DATA_W-1:0] res_q;

    always_comb begin
        case (sel)
            code_of(OP_ADD):  res_d = a + b;
            code_of(OP_SUB):  res_d = a - b;
            code_of(OP_NOT):  res_d = ~a;
            code_of(OP_NAND): res_d = ~(a & b);
            code_of(OP_NOR):  res_d = ~(a | b);
            code_of(OP_AND):  res_d = a & b;
            code_of(OP_OR):   res_d = a | b;
            code_of(OP_XOR):  res_d = a ^ b;
            default:          res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res = res_q;

    AST_ADD_WRAPS: assert property (@(posedge clk) disable iff (rst)
        sel == code_of(OP_ADD) |=> res_q == DATA_W'($past(a) + $past(b))); // R4

    AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
        sel == code_of(OP_XOR) |=> res_q == ($past(a) ^ $past(b))); // R7

    AST_RESULT_CLEAR: assert property (@(posedge clk)
        rst |=> res_q == '0); // R2

endmodule

// File: rtl/seq_alu_proc.sv
module seq_alu_proc
    import seq_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] led_n,
    output logic [NUM_OPS-1:0] opcode
);

    step_t             step;
    opcode_t           sel;
    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] result;

    step_counter u_step (
        .clk  (clk),
        .rst  (rst),
        .step (step)
    );

    onehot_decoder u_dec (
        .step (step),
        .sel  (sel)
    );

    operand_latch #(.DATA_W(DATA_W)) u_opa (
        .clk   (clk),
        .rst   (rst),
        .load  (strobe),
        .d     (a_in),
        .q_eff (op_a)
    );

    operand_latch #(.DATA_W(DATA_W)) u_opb (
        .clk   (clk),
        .rst   (rst),
        .load  (strobe),
        .d     (b_in),
        .q_eff (op_b)
    );

    alu_core #(.DATA_W(DATA_W)) u_alu (
        .clk (clk),
        .rst (rst),
        .sel (sel),
        .a   (op_a),
        .b   (op_b),
        .res (result)
    );

    assign led_n  = ~result;
    assign opcode = sel;

    AST_CODE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $countones(opcode) == 1); // R3

    AST_OP_ORDER: assert property (@(posedge clk) disable iff (rst)
        opcode == code_of(OP_XOR) |=> opcode == code_of(OP_ADD)); // R1

    AST_LED_STEADY: assert property (@(posedge clk) disable iff (rst)
        $stable(opcode) |-> $stable(led_n)); // R8

endmodule

// File: tb/seq_alu_proc_test.sv
`timescale 1ns/1ps
module seq_alu_proc_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strobe = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] led_n;
    logic [7:0]   opcode;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    int           m_cnt = 0;
    logic [W-1:0] m_ha  = '0;
    logic [W-1:0] m_hb  = '0;

    always #4 clk = ~clk;

    seq_alu_proc uut (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .a_in   (a_in),
        .b_in   (b_in),
        .led_n  (led_n),
        .opcode (opcode)
    );

    function automatic logic [W-1:0] model(int k, logic [W-1:0] x, logic [W-1:0] y);
        case (k)
            0: return W'((int'(x) + int'(y)) % 256);
            1: return W'((int'(x) - int'(y) + 256) % 256);
            2: return W'(255 - int'(x));
            3: return ~(x & y);
            4: return ~(x | y);
            5: return x & y;
            6: return x | y;
            default: return x ^ y;
        endcase
    endfunction

    function automatic string tag_of(int k);
        case (k)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(logic [7:0] got, logic [7:0] exp, string req);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    // one clock step: predict, wait edge, sample at negedge
    task automatic step(string extra);
        logic [W-1:0] ea;
        logic [W-1:0] eb;
        logic [W-1:0] r;
        string        t;
        ea = strobe ? a_in : m_ha;
        eb = strobe ? b_in : m_hb;
        r  = model(m_cnt, ea, eb);
        t  = tag_of(m_cnt);
        if (rst) begin
            ea = '0;
            eb = '0;
            r  = '0;
            m_cnt = 0;
            t = "R2";
        end else begin
            m_cnt = (m_cnt + 1) % 8;
        end
        m_ha = ea;
        m_hb = eb;
        @(posedge clk);
        @(negedge clk);
        chk(led_n, ~r, {t, " R8 R10 ", extra});
        chk(opcode, 8'(1 << m_cnt), {"R1 R3 ", extra});
    endtask

    initial begin
        // reset state
        rst = 1'b1;
        step("");
        step("");
        chk(led_n, 8'hFF, "R2");
        chk(opcode, 8'h01, "R2");
        rst = 1'b0;

        // near-exhaustive sweep, strobe held high
        strobe = 1'b1;
        for (int av = 0; av < 256; av++) begin
            for (int j = 0; j < 4; j++) begin
                a_in = W'(av);
                b_in = W'((av * 37 + j * 91 + 5) % 256);
                for (int s = 0; s < 8; s++) step("");
            end
        end

        // boundary operands
        a_in = 8'hFF; b_in = 8'h01;
        for (int s = 0; s < 8; s++) step("");
        a_in = 8'h00; b_in = 8'hFF;
        for (int s = 0; s < 8; s++) step("");

        // capture then hold with changing buses
        a_in = 8'hC3; b_in = 8'h5A;
        step("R9");
        strobe = 1'b0;
        for (int s = 0; s < 16; s++) begin
            a_in = W'(s * 29 + 7);
            b_in = W'(s * 53 + 1);
            step("R9");
        end

        // mid-cycle reset
        strobe = 1'b1;
        a_in = 8'h12; b_in = 8'h34;
        step(""); step(""); step("");
        rst = 1'b1;
        step("R2");
        chk(opcode, 8'h01, "R2");
        rst = 1'b0;
        strobe = 1'b0;
        a_in = 8'hAA; b_in = 8'h55;
        for (int s = 0; s < 8; s++) step("R2 R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule